// File: doc/BRIEF.md
# Event Signal Packet Framer

This block produces the narrow, read-only event stream that firmware sends to a host. Each packet opens with a 32-bit flag word that has a single bit set to name the event, and is followed by zero or more 32-bit payload words. All words go out least significant byte first. The packet bytes are encoded with Consistent Overhead Byte Stuffing (COBS) so that no zero byte occurs inside a packet, and each packet is closed by one zero byte. A host can therefore find packet boundaries by looking for zeros and discard packets it does not want.

After reset the framer announces the device table by itself. It first sends a table-start packet that carries the device count, then one descriptor packet per device in ascending index order. It reads each descriptor through a table read port. Only after that does it take requests, such as configuration acknowledgements, from a valid/ready request port. Each request carries a flag word, a payload length and up to `MAX_WORDS` payload words. The encoded bytes leave on a valid/ready byte port.

Top module: `evt_sig_framer`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` and `req_ready` are both low.
- R2: The first packet after reset has flag word 0x00000020 (bit 5, table start) and one payload word equal to `NUM_DEV`.
- R3: Next come `NUM_DEV` packets with flag 0x00000040 (bit 6, device instance), for device 0 upward. Each carries eight words read from `map_addr = dev*8 + k` for k = 0..7. That slot order is id, slot, clock domain, clock rate in Hz, read size, reads per sample, write size, writes per sample.
- R4: `req_ready` stays low until the table sequence has been sent, and it is high only between packets.
- R5: An accepted request becomes a packet of its flag word followed by `req_len` payload words. Word i is taken from `req_payload[32*i +: 32]`, and every word is sent least significant byte first. Flags such as read-ack (bit 3, with the register value as payload) pass through unchanged.
- R6: Each packet is COBS encoded. A code byte c (1..255) is followed by c-1 non-zero data bytes. Every code below 255 stands for one zero byte of the raw packet, except the last code of the packet. No zero byte occurs inside a packet, and each packet ends with exactly one 0x00 byte.
- R7: A run of 254 non-zero raw bytes closes its block with code 0xFF and implies no zero. If that run ends the packet, the encoding adds a final 0x01 block before the delimiter.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged on the next cycle.
- R9: A request with `req_len` = 0 produces a packet holding only the flag word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this cycle when valid |
| req_flag | input | 32 | One-hot event flag word |
| req_len | input | $clog2(MAX_WORDS+1) | Number of payload words |
| req_payload | input | MAX_WORDS*32 | Payload words, word 0 in the low bits |
| map_addr | output | $clog2(NUM_DEV*8) | Device table word address (device*8 + slot) |
| map_data | input | 32 | Device table word at `map_addr`, same cycle |
| out_data | output | 8 | Encoded byte |
| out_valid | output | 1 | Byte present |
| out_ready | input | 1 | Consumer takes the byte |

## Verification
The bench builds the framer with `NUM_DEV` = 3 and `MAX_WORDS` = 70. Three table packets make the index order of the descriptor packets visible. Seventy payload words give raw packets of up to 284 bytes, which brings both 254-byte boundary cases within reach: a run that ends exactly at the end of the packet, and a run that continues past the limit. Its device table and payloads contain many zero bytes. Random backpressure on `out_ready` exercises the hold rule.

// File: rtl/evt_sig_framer.sv
module evt_sig_framer #(
  parameter int NUM_DEV   = 3,
  parameter int MAX_WORDS = 8,
  localparam int LW = $clog2(MAX_WORDS + 1),
  localparam int AW = $clog2(NUM_DEV * 8)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [31:0]            req_flag,
  input  logic [LW-1:0]          req_len,
  input  logic [MAX_WORDS*32-1:0] req_payload,
  output logic [AW-1:0]          map_addr,
  input  logic [31:0]            map_data,
  output logic [7:0]             out_data,
  output logic                   out_valid,
  input  logic                   out_ready
);
  localparam int DW    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam int NWMAX = ((MAX_WORDS > 8) ? MAX_WORDS : 8) + 1;
  localparam int BW    = $clog2(4 * NWMAX + 2);
  localparam int WIW   = BW - 2;

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_CODE, S_DATA, S_DELIM} st_t;

  st_t                    st;
  logic                   map_pend, map_head, src_map, last_q, skip_q;
  logic [DW-1:0]          dev_cnt;
  logic [31:0]            flag_q;
  logic [LW-1:0]          len_q;
  logic [MAX_WORDS*32-1:0] pay_q;
  logic [BW-1:0]          p, q, plen, sel, nxt;
  logic [7:0]             n, cur;
  logic [WIW-1:0]         widx, pw;
  logic [31:0]            pword, word;
  logic                   at_end, full;

  assign plen   = src_map ? (map_head ? BW'(8) : BW'(36))
                          : (BW'({len_q, 2'b00}) + BW'(4));
  assign sel    = (st == S_SCAN) ? q : p;
  assign widx   = sel[BW-1:2];
  assign pw     = widx - WIW'(1);
  assign map_addr = AW'({dev_cnt, 3'b000}) + AW'(pw);
  assign pword  = 32'(pay_q >> {pw, 5'b00000});
  assign word   = (widx == '0) ? flag_q
                : src_map ? (map_head ? 32'(NUM_DEV) : map_data) : pword;
  assign cur    = 8'(word >> {sel[1:0], 3'b000});
  assign at_end = (q == plen);
  assign full   = (n == 8'd254);
  assign nxt    = q + BW'(skip_q);

  assign req_ready = (st == S_IDLE) && !map_pend;
  assign out_valid = st inside {S_CODE, S_DATA, S_DELIM};
  assign out_data  = (st == S_CODE) ? n + 8'd1 : (st == S_DATA) ? cur : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      map_pend <= 1'b1;
      map_head <= 1'b1;
      src_map <= 1'b0;
      dev_cnt <= '0;
      flag_q <= '0;
      len_q <= '0;
      pay_q <= '0;
      p <= '0;
      q <= '0;
      n <= '0;
      last_q <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          p <= '0;
          q <= '0;
          n <= '0;
          if (map_pend) begin
            src_map <= 1'b1;
            flag_q <= map_head ? 32'h20 : 32'h40;
            st <= S_SCAN;
          end else if (req_valid) begin
            src_map <= 1'b0;
            flag_q <= req_flag;
            len_q <= req_len;
            pay_q <= req_payload;
            st <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (full) begin
            last_q <= 1'b0;
            skip_q <= 1'b0;
            st <= S_CODE;
          end else if (at_end) begin
            last_q <= 1'b1;
            skip_q <= 1'b0;
            st <= S_CODE;
          end else if (cur == 8'h00) begin
            last_q <= 1'b0;
            skip_q <= 1'b1;
            st <= S_CODE;
          end else begin
            n <= n + 8'd1;
            q <= q + BW'(1);
          end
        end
        S_CODE: if (out_ready) begin
          if (n != 8'd0) st <= S_DATA;
          else if (last_q) st <= S_DELIM;
          else begin
            p <= nxt;
            q <= nxt;
            st <= S_SCAN;
          end
        end
        S_DATA: if (out_ready) begin
          if (p + BW'(1) == q) begin
            if (last_q) st <= S_DELIM;
            else begin
              p <= nxt;
              q <= nxt;
              n <= '0;
              st <= S_SCAN;
            end
          end else begin
            p <= p + BW'(1);
          end
        end
        S_DELIM: if (out_ready) begin
          st <= S_IDLE;
          if (src_map) begin
            if (map_head) map_head <= 1'b0;
            else if (dev_cnt == DW'(NUM_DEV - 1)) map_pend <= 1'b0;
            else dev_cnt <= dev_cnt + DW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evt_sig_framer_chk.sv
module evt_sig_framer_chk #(
  parameter int NUM_DEV = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_ready
);
  logic       inpk;
  logic [7:0] cnt;
  int         delims;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inpk <= 1'b0;
      cnt <= '0;
      delims <= 0;
    end else if (out_valid && out_ready) begin
      if (!inpk) begin
        inpk <= 1'b1;
        cnt <= out_data - 8'd1;
      end else if (cnt != 8'd0) begin
        cnt <= cnt - 8'd1;
      end else if (out_data == 8'h00) begin
        inpk <= 1'b0;
        if (delims <= NUM_DEV) delims <= delims + 1;
      end else begin
        cnt <= out_data - 8'd1;
      end
    end
  end

  a_r6_first_byte_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !inpk |-> out_data != 8'h00);
  a_r6_block_bytes_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && inpk && cnt != 8'd0 |-> out_data != 8'h00);
  a_r8_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  a_r4_table_before_requests: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> delims >= NUM_DEV + 1);
  a_r4_ready_between_packets: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !out_valid && !inpk);
endmodule

bind evt_sig_framer evt_sig_framer_chk #(.NUM_DEV(NUM_DEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/evt_sig_framer_test.sv
module evt_sig_framer_test;
  localparam int ND = 3;
  localparam int MW = 70;
  localparam int LW = $clog2(MW + 1);
  localparam int AW = $clog2(ND * 8);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [31:0] req_flag = '0;
  logic [LW-1:0] req_len = '0;
  logic [MW*32-1:0] req_payload = '0;
  logic [AW-1:0] map_addr;
  logic [31:0] map_data;
  logic [7:0] out_data;
  logic out_valid, out_ready = 1'b0;

  always #5 clk = ~clk;

  evt_sig_framer #(.NUM_DEV(ND), .MAX_WORDS(MW)) uut (.*);

  function automatic logic [31:0] mv(input int a);
    if (a % 5 == 2) return 32'h0;
    return (32'h1000_0001 * (a + 1)) ^ 32'h0080_4000;
  endfunction
  assign map_data = mv(int'(map_addr));

  int n_chk = 0, n_fail = 0, rdy_pct = 70, stall_bad = 0, r4_bad = 0, rx_delims = 0;
  bit done = 0;
  logic [7:0] rx[$], exp_q[$], raw_q[$], blk[$];
  int pkt_end[$];
  string pkt_tag[$];
  logic [31:0] wbuf [MW];

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic flush_blk();
    exp_q.push_back(8'(blk.size() + 1));
    foreach (blk[i]) exp_q.push_back(blk[i]);
    blk = {};
  endtask

  task automatic build(input logic [31:0] f, input int nw, input string tag);
    raw_q = {};
    for (int b = 0; b < 4; b++) raw_q.push_back(8'(f >> (8 * b)));
    for (int w = 0; w < nw; w++)
      for (int b = 0; b < 4; b++) raw_q.push_back(8'(wbuf[w] >> (8 * b)));
    blk = {};
    foreach (raw_q[i]) begin
      if (raw_q[i] == 8'h00) flush_blk();
      else begin
        blk.push_back(raw_q[i]);
        if (blk.size() == 254) flush_blk();
      end
    end
    flush_blk();
    exp_q.push_back(8'h00);
    pkt_end.push_back(exp_q.size());
    pkt_tag.push_back(tag);
  endtask

  task automatic send(input logic [31:0] f, input int nw, input string tag);
    build(f, nw, tag);
    @(negedge clk);
    req_flag = f;
    req_len = LW'(nw);
    for (int i = 0; i < MW; i++) req_payload[i*32 +: 32] = wbuf[i];
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always begin
    @(posedge clk);
    #1 out_ready = ($urandom % 100) < rdy_pct;
  end

  logic pv = 1'b0, pr = 1'b0;
  logic [7:0] pd = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pv && !pr && !(out_valid && out_data == pd)) stall_bad++;
      if (req_ready && rx_delims < ND + 1) r4_bad++;
      if (out_valid && out_ready) begin
        rx.push_back(out_data);
        if (out_data == 8'h00) rx_delims++;
      end
    end
    pv = out_valid;
    pr = out_ready;
    pd = out_data;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int start;
    int ok;
    int act;
    int expv;
    int wait_cyc;
    void'($urandom(32'd20240611));
    wbuf[0] = ND;
    build(32'h20, 1, "R2 table start");
    for (int d = 0; d < ND; d++) begin
      for (int k = 0; k < 8; k++) wbuf[k] = mv(d * 8 + k);
      build(32'h40, 8, "R3 device instance");
    end
    repeat (3) @(negedge clk);
    check(!out_valid && !req_ready, "R1 reset outputs", {out_valid, req_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !req_ready, "R1 first cycle after reset", {out_valid, req_ready}, 0);

    wbuf[0] = 32'h0012_0000;
    send(32'h08, 1, "R5 read ack with zero bytes");
    send(32'h01, 0, "R9 empty payload");
    for (int i = 0; i < 4; i++) wbuf[i] = 32'h0;
    send(32'h02, 4, "R6 all zero payload");
    wbuf[0] = 32'h1111_0000;
    for (int i = 1; i < 64; i++) wbuf[i] = 32'h1111_1111;
    send(32'h40, 64, "R7 run of 254 ends packet");
    for (int i = 0; i < 69; i++) wbuf[i] = 32'h2233_4455 + i;
    send(32'h04, 69, "R7 run longer than 254");
    for (int t = 0; t < 30; t++) begin
      int nw;
      if (t == 15) rdy_pct = 100;
      nw = $urandom % (MW + 1);
      for (int i = 0; i < nw; i++) begin
        logic [31:0] w;
        w = $urandom;
        for (int b = 0; b < 4; b++) if ($urandom % 4 == 0) w[8*b +: 8] = 8'h00;
        wbuf[i] = w;
      end
      send(32'h1 << ($urandom % 7), nw, "R5 R6 random packet");
    end

    wait_cyc = 0;
    while (rx.size() < exp_q.size() && wait_cyc < 40000) begin
      @(negedge clk);
      wait_cyc++;
    end
    check(rx.size() == exp_q.size(), "R6 total byte count", rx.size(), exp_q.size());
    start = 0;
    foreach (pkt_end[k]) begin
      ok = 1;
      act = 0;
      expv = 0;
      for (int i = start; i < pkt_end[k]; i++) begin
        if (ok && (i >= rx.size() || rx[i] !== exp_q[i])) begin
          ok = 0;
          act = (i < rx.size()) ? int'(rx[i]) : -1;
          expv = exp_q[i];
        end
      end
      check(ok == 1, pkt_tag[k], act, expv);
      start = pkt_end[k];
    end
    check(stall_bad == 0, "R8 byte held under stall", stall_bad, 0);
    check(r4_bad == 0, "R4 requests held off during table", r4_bad, 0);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule